// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block sends bytes as asynchronous serial frames: one start bit, eight data bits sent least significant bit first, and one stop bit. Each bit lasts sixteen periods of a 16x oversampling enable. Bytes are queued in a sixteen-entry first-in first-out buffer, which the host fills through a simple write strobe.

Automatic flow control can be turned on with a two-bit configuration field. When it is on, the active-low clear-to-send input decides whether the next queued byte may begin. A byte that has already started is always sent to the end. The clear-to-send level is read once per byte, halfway through its stop bit, and that reading alone decides whether the following byte goes straight out. While flow control is on, changes on clear-to-send raise no host interrupt, because the transmitter handles them without the host.

Top module: `uart_cts_tx`

## Requirements
- R1: During reset and right after it, `txd` is high, `fifo_full` is low and `cts_irq` is low.
- R2: A frame is `txd` low for 16 baud ticks, then the 8 bits of the byte starting at bit 0, each held for 16 ticks, then `txd` high for 16 ticks. Between frames the line stays high.
- R3: Automatic flow control is on only when both bits of `flow_cfg` are 1. Values 2'b00, 2'b01 and 2'b10 turn it off.
- R4: With flow control off, every queued byte is sent whatever the level of `cts_n`. Queued bytes follow one another with no gap, so their start bits are 160 ticks apart.
- R5: With flow control on, an idle transmitter starts no frame while the synchronized `cts_n` is high.
- R6: If `cts_n` goes high while a frame is being sent, that frame is still sent in full.
- R7: The level of `cts_n` is sampled on the 8th tick of the stop bit, after a two-flop synchronizer. If it is high there, the next byte is held back. If it is low there, the next queued byte starts right after the stop bit, even if `cts_n` has risen since.
- R8: After a hold, a queued byte starts on the third clock after `cts_n` falls, when a baud tick is present on every clock.
- R9: With flow control off, each change of the synchronized `cts_n` gives a single-cycle `cts_irq` pulse. With flow control on, `cts_irq` stays low.
- R10: The buffer holds 16 bytes and sends them in the order they were written. `fifo_full` is high when it holds 16, and a write made while it is full is dropped.
- R11: An idle transmitter that is allowed to send starts a start bit on the first baud tick after a byte has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe that queues `wr_data` |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | The buffer holds 16 bytes |
| baud_tick | input | 1 | 16x oversampling enable |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| flow_cfg | input | 2 | Flow control enable field; both bits set turns it on |
| txd | output | 1 | Serial output, high when idle |
| cts_irq | output | 1 | Pulse on a clear-to-send change while flow control is off |

## Verification
Several properties are checked on every cycle: the line is high whenever the transmitter is idle; a frame leaving idle was allowed by flow control in the cycle before it started; the buffer is never read while empty and stays full when a write arrives while it is full; and an interrupt pulse appears only after a real change on the synchronized input, and never while flow control is on. Other behaviour can only be shown by the bench's scenarios. These are the frame bit order, the back-to-back spacing, the exact clock on which a byte resumes after a hold, and the stop-bit midpoint rule. For the midpoint rule the bench releases clear-to-send a few clocks before and a few clocks after the sampling point and counts the frames that follow.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = d;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {STAGES{RST_VAL}};
    else        sync_q <= sync_d;
  end

  assign q = sync_q[STAGES-1];
endmodule

// File: rtl/uart_cts_fifo.sv
module uart_cts_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push, pull;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign push  = wr_en && !full;
  assign pull  = rd_en && !empty;
  assign rd_data = mem_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    if (pull) rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    if (push && !pull) cnt_d = cnt_q + 1'b1;
    else if (pull && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wptr_q] <= wr_data;
  end
endmodule

// File: rtl/uart_cts_engine.sv
module uart_cts_engine
  import uart_cts_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          have_data,
  input  logic          clear,
  input  logic [DW-1:0] din,
  output logic          pop,
  output logic          busy,
  output logic          txd
);
  localparam int TW  = $clog2(OSR);
  localparam int BW  = (DW > 1) ? $clog2(DW) : 1;
  localparam int MID = OSR / 2 - 1;

  tx_state_e     state_q, state_d;
  logic [TW-1:0] tick_q, tick_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] shift_q, shift_d;
  logic          hold_q, hold_d;
  logic          txd_q, txd_d;
  logic          last_tick, mid_tick, last_bit;

  assign last_tick = (tick_q == TW'(OSR-1));
  assign mid_tick  = (tick_q == TW'(MID));
  assign last_bit  = (bit_q == BW'(DW-1));

  always_comb begin
    state_d = state_q;
    tick_d  = tick_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    hold_d  = hold_q;
    txd_d   = txd_q;
    pop     = 1'b0;
    if (tick) begin
      unique case (state_q)
        TX_IDLE: begin
          if (have_data && clear) begin
            pop     = 1'b1;
            shift_d = din;
            state_d = TX_START;
            tick_d  = '0;
            hold_d  = 1'b0;
            txd_d   = 1'b0;
          end
        end
        TX_START: begin
          tick_d = tick_q + 1'b1;
          if (last_tick) begin
            state_d = TX_DATA;
            tick_d  = '0;
            bit_d   = '0;
            txd_d   = shift_q[0];
          end
        end
        TX_DATA: begin
          tick_d = tick_q + 1'b1;
          if (last_tick) begin
            tick_d  = '0;
            shift_d = shift_q >> 1;
            if (last_bit) begin
              state_d = TX_STOP;
              txd_d   = 1'b1;
            end else begin
              bit_d = bit_q + 1'b1;
              txd_d = shift_q[1];
            end
          end
        end
        TX_STOP: begin
          tick_d = tick_q + 1'b1;
          if (mid_tick) hold_d = !clear;
          if (last_tick) begin
            tick_d = '0;
            if (have_data && !hold_q) begin
              pop     = 1'b1;
              shift_d = din;
              state_d = TX_START;
              hold_d  = 1'b0;
              txd_d   = 1'b0;
            end else begin
              state_d = TX_IDLE;
            end
          end
        end
        default: state_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      hold_q  <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      hold_q  <= hold_d;
      txd_q   <= txd_d;
    end
  end

  assign busy = (state_q != TX_IDLE);
  assign txd  = txd_q;
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int OSR   = 16,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          fifo_full,
  input  logic          baud_tick,
  input  logic          cts_n,
  input  logic [1:0]    flow_cfg,
  output logic          txd,
  output logic          cts_irq
);
  logic          cts_sync;
  logic          flow_en;
  logic          clear;
  logic          fifo_empty;
  logic          pop;
  logic          busy;
  logic [DW-1:0] head;
  logic          cts_prev_q, cts_prev_d;
  logic          irq_q, irq_d;

  assign flow_en = &flow_cfg;
  assign clear   = !flow_en || !cts_sync;

  uart_cts_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_sync)
  );

  uart_cts_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(pop), .rd_data(head), .empty(fifo_empty), .full(fifo_full)
  );

  uart_cts_engine #(.DW(DW), .OSR(OSR)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .have_data(!fifo_empty),
    .clear(clear), .din(head), .pop(pop), .busy(busy), .txd(txd)
  );

  always_comb begin
    cts_prev_d = cts_sync;
    irq_d      = (cts_sync != cts_prev_q) && !flow_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_prev_q <= 1'b1;
      irq_q      <= 1'b0;
    end else begin
      cts_prev_q <= cts_prev_d;
      irq_q      <= irq_d;
    end
  end

  assign cts_irq = irq_q;
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic busy,
  input logic cts_sync,
  input logic flow_en,
  input logic cts_irq,
  input logic fifo_full,
  input logic fifo_empty,
  input logic wr_en,
  input logic pop
);
  p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_gate_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!flow_en || !cts_sync));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flow_en) |-> !cts_irq);

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cts_irq |-> ($past(cts_sync) != $past(cts_sync, 2)));

  p_pop_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);

  p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && !pop) |=> fifo_full);
endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .busy(busy), .cts_sync(cts_sync),
  .flow_en(flow_en), .cts_irq(cts_irq), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .wr_en(wr_en), .pop(pop)
);

// File: tb/sim_uart_cts_tx.sv
module sim_uart_cts_tx;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       fifo_full;
  logic       baud_tick;
  logic       cts_n;
  logic [1:0] flow_cfg;
  logic       txd;
  logic       cts_irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tick_div = 1;
  int tdiv_cnt = 0;
  int starts_seen = 0;
  int rx_n = 0;
  int frame_err = 0;
  logic [7:0] rx_q [0:63];
  int start_cyc [0:63];

  uart_cts_tx u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_full(fifo_full), .baud_tick(baud_tick), .cts_n(cts_n),
    .flow_cfg(flow_cfg), .txd(txd), .cts_irq(cts_irq)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tdiv_cnt >= tick_div - 1) begin
      tdiv_cnt  <= 0;
      baud_tick <= 1'b1;
    end else begin
      tdiv_cnt  <= tdiv_cnt + 1;
      baud_tick <= 1'b0;
    end
  end

  // Frame monitor: decodes txd by sampling each bit at its centre
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        if (starts_seen < 64) start_cyc[starts_seen] = cyc;
        starts_seen = starts_seen + 1;
        repeat (8 * tick_div - 1) @(negedge clk);
        if (txd !== 1'b0) frame_err = frame_err + 1;
        for (int i = 0; i < 8; i++) begin
          repeat (16 * tick_div) @(negedge clk);
          b[i] = txd;
        end
        repeat (16 * tick_div) @(negedge clk);
        if (txd !== 1'b1) frame_err = frame_err + 1;
        if (rx_n < 64) rx_q[rx_n] = b;
        rx_n = rx_n + 1;
      end
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic set_cts(input logic v);
    @(negedge clk);
    cts_n = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_eq("R1 txd", int'(txd), 1);
    check_eq("R1 fifo_full", int'(fifo_full), 0);
    check_eq("R1 cts_irq", int'(cts_irq), 0);
  endtask

  task automatic t_first_tick;
    int r0;
    r0 = rx_n;
    flow_cfg = 2'b00;
    cts_n = 1'b1;
    idle(4);
    push(8'h5A);
    check_eq("R11 still idle", int'(txd), 1);
    @(negedge clk);
    check_eq("R11 start bit", int'(txd), 0);
    idle(200);
    check_eq("R2 one frame", rx_n - r0, 1);
    check_eq("R2 data 5A", int'(rx_q[r0]), 'h5A);
  endtask

  task automatic t_no_flow;
    int r0, s0;
    r0 = rx_n; s0 = starts_seen;
    flow_cfg = 2'b00;
    cts_n = 1'b1;
    idle(4);
    push(8'h01); push(8'h80); push(8'hC7);
    idle(3 * 160 + 60);
    check_eq("R4 count", rx_n - r0, 3);
    check_eq("R4 byte0", int'(rx_q[r0]), 'h01);
    check_eq("R4 byte1", int'(rx_q[r0+1]), 'h80);
    check_eq("R4 byte2", int'(rx_q[r0+2]), 'hC7);
    check_eq("R4 gap", start_cyc[s0+1] - start_cyc[s0], 160);
    check_eq("R4 gap2", start_cyc[s0+2] - start_cyc[s0+1], 160);
  endtask

  task automatic t_hold_idle;
    int r0, c0;
    flow_cfg = 2'b11;
    set_cts(1'b1);
    idle(10);
    r0 = rx_n;
    push(8'h99);
    idle(400);
    check_eq("R5 held", rx_n - r0, 0);
    check_eq("R5 line high", int'(txd), 1);
    @(negedge clk);
    cts_n = 1'b0;
    c0 = cyc;
    idle(200);
    check_eq("R8 resumed", rx_n - r0, 1);
    check_eq("R8 byte", int'(rx_q[r0]), 'h99);
    check_eq("R8 latency", start_cyc[starts_seen-1] - c0, 3);
  endtask

  task automatic t_mid_char;
    int r0, s0;
    flow_cfg = 2'b11;
    set_cts(1'b0);
    idle(10);
    r0 = rx_n; s0 = starts_seen;
    push(8'h3C); push(8'hC3);
    wait (starts_seen == s0 + 1);
    repeat (40) @(negedge clk);
    cts_n = 1'b1;
    idle(450);
    check_eq("R6 frame completed", rx_n - r0, 1);
    check_eq("R6 byte", int'(rx_q[r0]), 'h3C);
    set_cts(1'b0);
    idle(200);
    check_eq("R8 second sent", rx_n - r0, 2);
    check_eq("R8 second byte", int'(rx_q[r0+1]), 'hC3);
  endtask

  task automatic t_midpoint;
    int r0, s0;
    flow_cfg = 2'b11;
    set_cts(1'b0);
    idle(10);
    // released just before the stop-bit sampling point: next byte held
    r0 = rx_n; s0 = starts_seen;
    push(8'h11); push(8'h22);
    wait (starts_seen == s0 + 1);
    repeat (140) @(negedge clk);
    cts_n = 1'b1;
    idle(450);
    check_eq("R7 held before mid", rx_n - r0, 1);
    set_cts(1'b0);
    idle(200);
    check_eq("R7 drained", rx_n - r0, 2);
    check_eq("R7 byte 22", int'(rx_q[r0+1]), 'h22);
    // released just after the sampling point: next byte still goes
    r0 = rx_n; s0 = starts_seen;
    push(8'h44); push(8'h55); push(8'h66);
    wait (starts_seen == s0 + 1);
    repeat (152) @(negedge clk);
    cts_n = 1'b1;
    idle(600);
    check_eq("R7 sent after mid", rx_n - r0, 2);
    check_eq("R7 byte 55", int'(rx_q[r0+1]), 'h55);
    check_eq("R7 back to back", start_cyc[s0+1] - start_cyc[s0], 160);
    set_cts(1'b0);
    idle(200);
    check_eq("R7 third", int'(rx_q[r0+2]), 'h66);
  endtask

  task automatic t_irq;
    int n;
    flow_cfg = 2'b00;
    set_cts(1'b0);
    idle(8);
    n = 0;
    set_cts(1'b1);
    repeat (6) begin @(negedge clk); if (cts_irq) n++; end
    check_eq("R9 pulse when off", n, 1);
    flow_cfg = 2'b11;
    idle(2);
    n = 0;
    set_cts(1'b0);
    repeat (6) begin @(negedge clk); if (cts_irq) n++; end
    check_eq("R9 quiet when on", n, 0);
    flow_cfg = 2'b10;
    idle(2);
    n = 0;
    set_cts(1'b1);
    repeat (6) begin @(negedge clk); if (cts_irq) n++; end
    check_eq("R3 one bit no flow irq", n, 1);
  endtask

  task automatic t_one_bit_cfg;
    int r0;
    flow_cfg = 2'b01;
    set_cts(1'b1);
    idle(6);
    r0 = rx_n;
    push(8'hE1);
    idle(200);
    check_eq("R3 sends with cts high", rx_n - r0, 1);
    check_eq("R3 byte", int'(rx_q[r0]), 'hE1);
  endtask

  task automatic t_full;
    int r0;
    flow_cfg = 2'b11;
    set_cts(1'b1);
    idle(6);
    r0 = rx_n;
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
    check_eq("R10 full", int'(fifo_full), 1);
    push(8'hFF);
    check_eq("R10 still full", int'(fifo_full), 1);
    set_cts(1'b0);
    idle(17 * 160 + 100);
    check_eq("R10 count", rx_n - r0, 16);
    for (int i = 0; i < 16; i++)
      check_eq("R10 order", int'(rx_q[r0+i]), 'h40 + i);
    check_eq("R10 not full", int'(fifo_full), 0);
  endtask

  task automatic t_slow_tick;
    int r0;
    flow_cfg = 2'b00;
    idle(4);
    tick_div = 3;
    idle(4);
    r0 = rx_n;
    push(8'hA5);
    idle(10 * 48 + 60);
    check_eq("R2 slow frame", rx_n - r0, 1);
    check_eq("R2 slow byte", int'(rx_q[r0]), 'hA5);
    tick_div = 1;
    idle(4);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    baud_tick = 1'b0;
    cts_n = 1'b1;
    flow_cfg = 2'b00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_first_tick();
    t_no_flow();
    t_hold_idle();
    t_mid_char();
    t_midpoint();
    t_irq();
    t_one_bit_cfg();
    t_full();
    t_slow_tick();
    check_eq("R2 frame errors", frame_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks = checks + 1;
    fails  = fails + 1;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule